// File: doc/BRIEF.md
# Accumulator ALU with Registered Flag Byte

This block is the arithmetic and logic stage of a small accumulator-based processor. Each cycle it takes the accumulator value, a second operand byte, the current flag byte and a 5-bit operation code. It computes the new accumulator value, whether the accumulator should be written, and the updated flag byte, and registers all three on the next rising clock edge. It has no handshake: a new operation may be presented every cycle, and its outputs appear one cycle later. Instruction fetch, operand fetch and the register file sit outside the block.

The flag byte carries five live flags: sign, zero, auxiliary (nibble) carry, even parity and carry. The block follows the processor's own rules for these flags, and those rules differ from a textbook ALU in four places. After a subtraction the auxiliary carry means "no nibble borrow". The logical AND takes its auxiliary carry from the OR of bit 3 of the two inputs. Add-with-carry widens the nibble test when the carry-in is set. Decimal adjust is a two-step correction that can set carry but never clears it.

Top module: `acc_alu_core`

## Requirements
- R1: All outputs are registered, with one cycle of latency from the inputs. A synchronous active-high reset drives `result_o` to 0x00, `acc_we_o` to 0 and `flags_o` to the `FLAG_RST` value (0x02 by default).
- R2: In `flags_o`, sign is at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 always reads 1, and bits 5 and 3 always read 0, whatever `flags_i` holds.
- R3: For ADD(0), ADC(1), SUB(2), SBB(3), AND(4), XOR(5), OR(6), CMP(7) and DAA(12), the block recomputes sign, zero and parity from the 8-bit result. Sign is bit 7, zero means the result is 0x00, and parity is 1 when the result has an even number of one bits, so 0x00 gives parity 1. For CMP the 8-bit difference is used.
- R4: ADD(0) writes acc+opnd and ADC(1) writes acc+opnd+carry_in. Carry is the carry out of bit 7. Auxiliary carry is set when the sum of the two low nibbles is above 0x0F, or at least 0x0F when ADC runs with carry_in set.
- R5: SUB(2) writes acc-opnd and SBB(3) writes acc-opnd-carry_in, both modulo 256. Carry is set exactly when opnd (plus carry_in for SBB) is greater than acc.
- R6: For SUB(2) and CMP(7), auxiliary carry is set when the low nibble of opnd is less than or equal to the low nibble of acc. For SBB(3) with carry_in set, the nibble must be strictly less. For SBB with carry_in clear, the rule is the same as SUB.
- R7: CMP(7) updates all five flags exactly as SUB does. It leaves `acc_we_o` at 0 and outputs the unchanged acc on `result_o`.
- R8: AND(4) writes acc&opnd, sets auxiliary carry to bit 3 of (acc|opnd) and clears carry. XOR(5) and OR(6) write their results and clear both auxiliary carry and carry.
- R9: Each rotate writes its result and changes only the carry flag. RLC(8) rotates left and copies bit 7 into bit 0 and into carry. RRC(9) rotates right and copies bit 0 into bit 7 and into carry. RAL(10) shifts left with the old carry entering bit 0 and bit 7 leaving into carry. RAR(11) shifts right with the old carry entering bit 7 and bit 0 leaving into carry.
- R10: CMA(13) writes ~acc and leaves all flags unchanged. STC(14) sets carry and CMC(15) inverts carry. STC and CMC leave the other flags unchanged, do not write, and output acc.
- R11: DAA(12) works in two steps. First, if the low nibble is above 9 or auxiliary carry is set, it adds 0x06 and sets auxiliary carry from the nibble overflow; otherwise auxiliary carry is kept. Second, if the high nibble of that value is above 9 or carry is set, it adds 0x60. Carry is set if either step overflows and is never cleared.
- R12: Op codes 16 to 31 output acc on `result_o`, leave `acc_we_o` at 0 and leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 5 | Operation code (R3 to R12) |
| acc_i | input | DATA_W | Current accumulator value |
| opnd_i | input | DATA_W | Second operand byte |
| flags_i | input | 8 | Current flag byte; carry and auxiliary carry are the incoming flags |
| result_o | output | DATA_W | Registered result |
| acc_we_o | output | 1 | Registered accumulator write enable |
| flags_o | output | 8 | Registered flag byte |

## Verification
The bench builds the block with its defaults: DATA_W of 8, which makes the nibble split 4/4 and fixes decimal adjust to two BCD digits, and FLAG_RST of 0x02. With these values every carry and nibble boundary of a byte can be reached. Directed vectors cover the boundary cases: equal operands in subtraction, a zero operand with a borrow in, a nibble sum of exactly 0x0F, decimal adjust with both stages firing and with carry held, and flag inputs that set the reserved bits. Random bytes across all 32 op codes, including the unused ones, then check the same expected-value model cycle by cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 8;
  localparam int N_OPS  = 16;

  // flag byte bit positions
  localparam int FB_SIGN = 7;
  localparam int FB_ZERO = 6;
  localparam int FB_HALF = 4;
  localparam int FB_PAR  = 2;
  localparam int FB_ONE  = 1;
  localparam int FB_CY   = 0;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_AND = 5'd4,  OP_XOR = 5'd5,  OP_OR  = 5'd6,  OP_CMP = 5'd7,
    OP_RLC = 5'd8,  OP_RRC = 5'd9,  OP_RAL = 5'd10, OP_RAR = 5'd11,
    OP_DAA = 5'd12, OP_CMA = 5'd13, OP_STC = 5'd14, OP_CMC = 5'd15
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic              sub_i,
  input  logic              use_carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              half_o
);
  localparam int NIB_W = DATA_W / 2;

  logic              cin_eff;
  logic [DATA_W:0]   full;
  logic [NIB_W:0]    low;

  always_comb begin
    cin_eff = use_carry_i & carry_i;
    if (sub_i) begin
      full    = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_eff};
      low     = {1'b0, a_i[NIB_W-1:0]} - {1'b0, b_i[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin_eff};
      carry_o = full[DATA_W];        // borrow out
      half_o  = ~low[NIB_W];         // set when the low nibble did not borrow
    end else begin
      full    = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_eff};
      low     = {1'b0, a_i[NIB_W-1:0]} + {1'b0, b_i[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin_eff};
      carry_o = full[DATA_W];
      half_o  = low[NIB_W];
    end
    res_o = full[DATA_W-1:0];
  end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic              half_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              half_o,
  output logic              carry_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W:0] ADJ_LO = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] ADJ_HI = ADJ_LO << NIB_W;
  localparam logic [NIB_W-1:0] DIGIT_MAX = NIB_W'(9);

  logic            lo_fix, hi_fix, cy_mid;
  logic [NIB_W:0]  lo_sum;
  logic [DATA_W:0] step1, step2;

  always_comb begin
    lo_fix  = (a_i[NIB_W-1:0] > DIGIT_MAX) | half_i;
    lo_sum  = {1'b0, a_i[NIB_W-1:0]} + (NIB_W+1)'(6);
    step1   = {1'b0, a_i} + (lo_fix ? ADJ_LO : '0);
    half_o  = lo_fix ? lo_sum[NIB_W] : half_i;
    cy_mid  = carry_i | step1[DATA_W];
    hi_fix  = (step1[DATA_W-1:NIB_W] > DIGIT_MAX) | cy_mid;
    step2   = step1 + (hi_fix ? ADJ_HI : '0);
    carry_o = cy_mid | step2[DATA_W];   // sticky: only ever set here
    res_o   = step2[DATA_W-1:0];
  end
endmodule

// File: rtl/acc_alu_bitwise.sv
module acc_alu_bitwise
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  input  logic              half_i,
  output logic [DATA_W-1:0] res_o,
  output logic              we_o,
  output logic              carry_o,
  output logic              half_o,
  output logic              szp_o
);
  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W-1:0] either;
  assign either = a_i | b_i;

  always_comb begin
    res_o   = a_i;
    we_o    = 1'b0;
    carry_o = carry_i;
    half_o  = half_i;
    szp_o   = 1'b0;
    case (op_i)
      OP_AND: begin
        res_o = a_i & b_i; we_o = 1'b1; szp_o = 1'b1;
        carry_o = 1'b0; half_o = either[NIB_W-1];
      end
      OP_XOR: begin
        res_o = a_i ^ b_i; we_o = 1'b1; szp_o = 1'b1;
        carry_o = 1'b0; half_o = 1'b0;
      end
      OP_OR: begin
        res_o = either; we_o = 1'b1; szp_o = 1'b1;
        carry_o = 1'b0; half_o = 1'b0;
      end
      OP_RLC: begin
        res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]}; we_o = 1'b1; carry_o = a_i[DATA_W-1];
      end
      OP_RRC: begin
        res_o = {a_i[0], a_i[DATA_W-1:1]}; we_o = 1'b1; carry_o = a_i[0];
      end
      OP_RAL: begin
        res_o = {a_i[DATA_W-2:0], carry_i}; we_o = 1'b1; carry_o = a_i[DATA_W-1];
      end
      OP_RAR: begin
        res_o = {carry_i, a_i[DATA_W-1:1]}; we_o = 1'b1; carry_o = a_i[0];
      end
      OP_CMA: begin
        res_o = ~a_i; we_o = 1'b1;
      end
      OP_STC: carry_o = 1'b1;
      OP_CMC: carry_o = ~carry_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int               DATA_W   = 8,
  parameter logic [FLAG_W-1:0] FLAG_RST = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_we_o,
  output logic [FLAG_W-1:0] flags_o
);
  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic cy_in, half_in;
  assign cy_in   = flags_i[FB_CY];
  assign half_in = flags_i[FB_HALF];

  // arithmetic path
  logic              as_sub, as_usec, as_cy, as_half;
  logic [DATA_W-1:0] as_res;
  assign as_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign as_usec = (op == OP_ADC) || (op == OP_SBB);

  acc_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_i(acc_i), .b_i(opnd_i), .carry_i(cy_in), .sub_i(as_sub),
    .use_carry_i(as_usec), .res_o(as_res), .carry_o(as_cy), .half_o(as_half)
  );

  // decimal adjust path
  logic [DATA_W-1:0] da_res;
  logic              da_cy, da_half;
  acc_alu_decadj #(.DATA_W(DATA_W)) u_decadj (
    .a_i(acc_i), .half_i(half_in), .carry_i(cy_in),
    .res_o(da_res), .half_o(da_half), .carry_o(da_cy)
  );

  // logic, rotate and carry-only path
  logic [DATA_W-1:0] bw_res;
  logic              bw_we, bw_cy, bw_half, bw_szp;
  acc_alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .carry_i(cy_in), .half_i(half_in),
    .res_o(bw_res), .we_o(bw_we), .carry_o(bw_cy), .half_o(bw_half), .szp_o(bw_szp)
  );

  // result select and flag assembly
  logic [DATA_W-1:0] res_d, szp_src;
  logic [FLAG_W-1:0] flags_d;
  logic              we_d, cy_d, half_d, szp_upd, sign_d, zero_d, par_d;

  always_comb begin
    res_d   = acc_i;
    we_d    = 1'b0;
    cy_d    = cy_in;
    half_d  = half_in;
    szp_upd = 1'b0;
    szp_src = acc_i;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_d = as_res; we_d = 1'b1; cy_d = as_cy; half_d = as_half;
        szp_upd = 1'b1; szp_src = as_res;
      end
      OP_CMP: begin
        cy_d = as_cy; half_d = as_half; szp_upd = 1'b1; szp_src = as_res;
      end
      OP_DAA: begin
        res_d = da_res; we_d = 1'b1; cy_d = da_cy; half_d = da_half;
        szp_upd = 1'b1; szp_src = da_res;
      end
      default: begin
        res_d = bw_res; we_d = bw_we; cy_d = bw_cy; half_d = bw_half;
        szp_upd = bw_szp; szp_src = bw_res;
      end
    endcase

    sign_d = szp_upd ? szp_src[DATA_W-1] : flags_i[FB_SIGN];
    zero_d = szp_upd ? ~|szp_src         : flags_i[FB_ZERO];
    par_d  = szp_upd ? ~^szp_src         : flags_i[FB_PAR];

    flags_d          = '0;
    flags_d[FB_SIGN] = sign_d;
    flags_d[FB_ZERO] = zero_d;
    flags_d[FB_HALF] = half_d;
    flags_d[FB_PAR]  = par_d;
    flags_d[FB_ONE]  = 1'b1;
    flags_d[FB_CY]   = cy_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o <= '0;
      acc_we_o <= 1'b0;
      flags_o  <= FLAG_RST;
    end else begin
      result_o <= res_d;
      acc_we_o <= we_d;
      flags_o  <= flags_d;
    end
  end

  // ---------------- assertions ----------------
  logic arith_like;
  assign arith_like = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBB) ||
                      (op == OP_AND) || (op == OP_XOR) || (op == OP_OR)  || (op == OP_DAA);

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
    (flags_o[FB_ONE] && !flags_o[5] && !flags_o[3]));

  p_parity_r3: assert property (@(posedge clk) disable iff (rst)
    arith_like |=> (flags_o[FB_PAR] == ~^result_o));

  p_zero_r3: assert property (@(posedge clk) disable iff (rst)
    arith_like |=> (flags_o[FB_ZERO] == (result_o == '0)));

  p_cmp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |=> (!acc_we_o && result_o == $past(acc_i)));

  p_logic_clear_r8: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_OR) || (op == OP_XOR)) |=> (!flags_o[FB_CY] && !flags_o[FB_HALF]));

  p_cma_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMA) |=> ((flags_o & 8'hD5) == ($past(flags_i) & 8'hD5)));

  p_daa_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    ((op == OP_DAA) && cy_in) |=> flags_o[FB_CY]);

  p_unused_r12: assert property (@(posedge clk) disable iff (rst)
    (op_i >= OP_W'(N_OPS)) |=> (!acc_we_o && result_o == $past(acc_i)));
endmodule

// File: tb/acc_alu_core_bench.sv
module acc_alu_core_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op_i = '0;
  logic [7:0] acc_i = '0, opnd_i = '0, flags_i = '0;
  logic [7:0] result_o, flags_o;
  logic       acc_we_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_core u_acc_alu_core (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .flags_i(flags_i), .result_o(result_o), .acc_we_o(acc_we_o), .flags_o(flags_o)
  );

  function automatic string tag_of(input int op);
    case (op)
      0, 1:   return "R4";
      2, 3:   return "R5";
      7:      return "R7";
      4, 5, 6: return "R8";
      8, 9, 10, 11: return "R9";
      12:     return "R11";
      13, 14, 15: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic int even_ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return ((n % 2) == 0) ? 1 : 0;
  endfunction

  // behavioural expected-value model
  task automatic model(input int op, input int a, input int b, input int f,
                       output int res, output int we, output int fo);
    int cin, c, ac, s, z, p, szp, src, t, lo;
    cin = f & 1; c = cin; ac = (f >> 4) & 1;
    s = (f >> 7) & 1; z = (f >> 6) & 1; p = (f >> 2) & 1;
    res = a; we = 0; szp = 0; src = a;
    case (op)
      0: begin t = a + b; res = t & 255; c = (t > 255); ac = ((a & 15) + (b & 15)) > 15;
               we = 1; szp = 1; src = res; end
      1: begin t = a + b + cin; res = t & 255; c = (t > 255);
               ac = cin ? (((a & 15) + (b & 15)) >= 15) : (((a & 15) + (b & 15)) > 15);
               we = 1; szp = 1; src = res; end
      2, 7: begin src = (a - b) & 255; c = (b > a); ac = ((b & 15) <= (a & 15)); szp = 1;
               if (op == 2) begin res = src; we = 1; end end
      3: begin src = (a - b - cin) & 255; c = ((b + cin) > a);
               ac = cin ? ((b & 15) < (a & 15)) : ((b & 15) <= (a & 15));
               res = src; we = 1; szp = 1; end
      4: begin res = a & b; ac = ((a | b) >> 3) & 1; c = 0; we = 1; szp = 1; src = res; end
      5: begin res = a ^ b; ac = 0; c = 0; we = 1; szp = 1; src = res; end
      6: begin res = a | b; ac = 0; c = 0; we = 1; szp = 1; src = res; end
      8: begin c = (a >> 7) & 1; res = ((a << 1) | (a >> 7)) & 255; we = 1; end
      9: begin c = a & 1; res = (a >> 1) | ((a & 1) << 7); we = 1; end
      10: begin c = (a >> 7) & 1; res = ((a << 1) | cin) & 255; we = 1; end
      11: begin c = a & 1; res = (a >> 1) | (cin << 7); we = 1; end
      12: begin
        t = a; lo = a & 15;
        if (lo > 9 || ac == 1) begin ac = ((lo + 6) > 15); t = t + 6; if (t > 255) c = 1; end
        if (((t >> 4) & 15) > 9 || c == 1) begin t = t + 96; if (t > 255) c = 1; end
        res = t & 255; we = 1; szp = 1; src = res;
      end
      13: begin res = (~a) & 255; we = 1; end
      14: c = 1;
      15: c = 1 - cin;
      default: ;
    endcase
    if (szp == 1) begin s = (src >> 7) & 1; z = (src == 0); p = even_ones(src); end
    fo = (s << 7) | (z << 6) | (ac << 4) | (p << 2) | 2 | c;
  endtask

  // drive at a falling edge, check at the next falling edge (one register stage)
  task automatic run_vec(input int op, input int a, input int b, input int f);
    int er, ew, ef;
    model(op, a, b, f, er, ew, ef);
    op_i = op[4:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = f[7:0];
    @(negedge clk);
    n_vec++;
    if (result_o !== er[7:0] || acc_we_o !== ew[0] || flags_o !== ef[7:0]) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: got res=%02h we=%0b fl=%02h exp res=%02h we=%0b fl=%02h",
               tag_of(op), op, a, b, f, result_o, acc_we_o, flags_o, er[7:0], ew[0], ef[7:0]);
    end
    // R2: fixed bits of the flag byte
    n_vec++;
    if (flags_o[1] !== 1'b1 || flags_o[5] !== 1'b0 || flags_o[3] !== 1'b0) begin
      n_bad++;
      $display("FAIL R2 fixed flag bits: got fl=%02h exp bit1=1 bit5=0 bit3=0", flags_o);
    end
  endtask

  task automatic check_reset();
    n_vec++;
    if (result_o !== 8'h00 || acc_we_o !== 1'b0 || flags_o !== 8'h02) begin
      n_bad++;
      $display("FAIL R1 reset state: got res=%02h we=%0b fl=%02h exp res=00 we=0 fl=02",
               result_o, acc_we_o, flags_o);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();                       // R1 at power-up
    rst = 1'b0;

    // R4 add boundaries
    run_vec(0, 8'h80, 8'h80, 8'h00);     // zero result, carry, parity (R3)
    run_vec(0, 8'h0F, 8'h01, 8'h00);     // nibble overflow
    run_vec(1, 8'h08, 8'h07, 8'h01);     // nibble sum exactly 0x0F with carry in
    run_vec(1, 8'h08, 8'h06, 8'h01);
    run_vec(1, 8'hFF, 8'h00, 8'h01);
    // R5 / R6 subtract boundaries
    run_vec(2, 8'h00, 8'h00, 8'h01);     // equal operands: no carry, AC set, zero (R3)
    run_vec(2, 8'h01, 8'h02, 8'h00);
    run_vec(3, 8'h00, 8'h00, 8'h01);     // zero operand with borrow in
    run_vec(3, 8'h05, 8'h05, 8'h01);     // equal nibbles with borrow: AC clear
    run_vec(3, 8'h05, 8'h05, 8'h00);
    run_vec(3, 8'h10, 8'hFF, 8'h01);
    // R7 compare
    run_vec(7, 8'h10, 8'h20, 8'h00);
    run_vec(7, 8'h42, 8'h42, 8'hFF);
    // R8 logic
    run_vec(4, 8'hF0, 8'h08, 8'h01);
    run_vec(4, 8'hF0, 8'h07, 8'h11);
    run_vec(5, 8'h55, 8'h55, 8'hFF);
    run_vec(6, 8'h01, 8'h02, 8'hFF);
    // R9 rotates
    run_vec(8, 8'h80, 8'h00, 8'h00);
    run_vec(9, 8'h01, 8'h00, 8'h00);
    run_vec(10, 8'h7F, 8'h00, 8'h01);
    run_vec(11, 8'hFE, 8'h00, 8'h01);
    // R10 carry-only and complement, reserved bits set on input
    run_vec(13, 8'h3C, 8'h00, 8'h28);
    run_vec(13, 8'hA5, 8'h00, 8'hD5);
    run_vec(14, 8'h12, 8'h00, 8'h00);
    run_vec(15, 8'h12, 8'h00, 8'h01);
    run_vec(15, 8'h12, 8'h00, 8'hFE);
    // R11 decimal adjust
    run_vec(11 + 1, 8'h9A, 8'h00, 8'h00);
    run_vec(12, 8'h00, 8'h00, 8'h01);    // carry held, 0x60 added
    run_vec(12, 8'h15, 8'h00, 8'h10);
    run_vec(12, 8'h99, 8'h00, 8'h00);
    run_vec(12, 8'hFF, 8'h00, 8'h00);
    run_vec(12, 8'h0A, 8'h00, 8'h11);
    // R12 unused codes
    run_vec(16, 8'h5A, 8'h33, 8'hD7);
    run_vec(31, 8'hC3, 8'h11, 8'h00);

    // random sweep over every code
    for (int op = 0; op < 32; op++) begin
      for (int k = 0; k < 300; k++)
        run_vec(op, int'($urandom_range(255)), int'($urandom_range(255)), int'($urandom_range(255)));
    end

    // R1 reset applied mid-run
    op_i = 5'd0; acc_i = 8'hFF; opnd_i = 8'hFF; flags_i = 8'hFF; rst = 1'b1;
    @(negedge clk);
    check_reset();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule